// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns a set of active-low external interrupt pins (two by default) into pending flags for a downstream interrupt controller. Each pin is asynchronous to the core clock. It first passes through a multi-flop synchronizer, and only then is it examined. A per-input mode bit picks one of two capture styles. In level mode the flag is a plain copy of the inverted, synchronized pin, so it stays high for as long as the source holds the pin low. In edge mode a high-to-low transition of the synchronized pin latches the flag. The latched flag then stays high until the controller acknowledges the vector or software clears it.

The interrupt controller sends a one-cycle vector-acknowledge pulse per input when it takes that input's request. A software write port can set or clear any subset of the flags, selected by a mask. Software writes only affect edge-mode flags; a level-mode flag always reflects the pin. Priority arbitration, vector generation and debounce filtering are done elsewhere.

Top module: `ext_int_conditioner`

## Requirements
- R1: While reset is asserted and after it is released with all pins high, every `pending` bit is 0.
- R2: With the default two synchronizer stages, a pin change shows on `pending` at the third rising clock edge after the pin is presented, and not at the second.
- R3: In level mode (`edgeMode[i]` = 0), `pending[i]` equals the inverse of `pinN[i]` as sampled three rising edges earlier. It rises when the pin is low and falls when the pin returns high.
- R4: In level mode, `vecAck[i]` has no effect. If the pin is still low, `pending[i]` stays 1 so that a new request is produced.
- R5: In level mode, a software write to bit i has no effect on `pending[i]`.
- R6: In edge mode (`edgeMode[i]` = 1), a high-to-low transition of the pin sets `pending[i]` three edges later. A pin that stays low, or that rises, sets nothing new.
- R7: In edge mode, a set flag holds while there is no acknowledge and no software clear, whatever the pin does.
- R8: In edge mode, a one-cycle `vecAck[i]` clears `pending[i]` at that clock edge.
- R9: In edge mode, a falling edge whose detection coincides with `vecAck[i]` leaves `pending[i]` set.
- R10: In edge mode, when `swWrEn` is 1 and `swWrMask[i]` is 1, `pending[i]` takes `swWrVal[i]` at that edge. A software set wins over a same-cycle acknowledge. A falling edge wins over a same-cycle software clear. Bits with `swWrMask` 0 are untouched.
- R11: Each input's mode, acknowledge and pin act only on that input's own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pinN | input | NUM_IN | Active-low asynchronous interrupt pins |
| edgeMode | input | NUM_IN | Per-input capture mode: 1 edge, 0 level |
| vecAck | input | NUM_IN | One-cycle vector-acknowledge pulse per input |
| swWrEn | input | 1 | Software write strobe for the flags |
| swWrMask | input | NUM_IN | Selects which flags a software write touches |
| swWrVal | input | NUM_IN | Values written to the selected flags |
| pending | output | NUM_IN | Pending flag per input |

## Verification
The checker relates the flags to the pins on every cycle. It covers level-mode tracking with its fixed latency, edge-mode setting on a delayed falling transition, holding without a clear, and clearing by acknowledge unless a falling edge arrives in the same cycle. The bench scenarios are needed for the precise ordering of software writes against acknowledges and edges, for mask isolation, for mode independence between inputs, and for the absence of a second set while a pin stays low.

// File: rtl/ext_int_pkg.sv
package ext_int_pkg;

  // Per-input command from control to datapath for one clock edge.
  typedef struct packed {
    logic track;   // flag copies the inverted synchronized pin
    logic setF;    // flag goes to 1
    logic clrF;    // flag goes to 0
  } flagStrobe_t;

endpackage

// File: rtl/ext_int_datapath.sv
module ext_int_datapath
  import ext_int_pkg::*;
#(
  parameter int NUM_IN      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic        [NUM_IN-1:0]        pinN,
  input  flagStrobe_t [NUM_IN-1:0]        strobeVec,
  output logic        [NUM_IN-1:0]        fallSeen,
  output logic        [NUM_IN-1:0]        flagQ
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   prevSync;
    logic                   syncPin;
    logic                   flagNext;

    // Synchronizer: idle level of an active-low pin is high.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        syncChain <= '1;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], pinN[i]};
      end
    end

    assign syncPin = syncChain[LAST];

    // History of the synchronized pin for transition detection.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prevSync <= 1'b1;
      end else begin
        prevSync <= syncPin;
      end
    end

    assign fallSeen[i] = prevSync & ~syncPin;

    // Flag next-state selection, driven by control strobes.
    always_comb begin
      flagNext = flagQ[i];
      if (strobeVec[i].track) begin
        flagNext = ~syncPin;
      end else if (strobeVec[i].setF) begin
        flagNext = 1'b1;
      end else if (strobeVec[i].clrF) begin
        flagNext = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flagQ[i] <= 1'b0;
      end else begin
        flagQ[i] <= flagNext;
      end
    end
  end

endmodule

// File: rtl/ext_int_control.sv
module ext_int_control
  import ext_int_pkg::*;
#(
  parameter int NUM_IN = 2
) (
  input  logic        [NUM_IN-1:0] edgeMode,
  input  logic        [NUM_IN-1:0] vecAck,
  input  logic                     swWrEn,
  input  logic        [NUM_IN-1:0] swWrMask,
  input  logic        [NUM_IN-1:0] swWrVal,
  input  logic        [NUM_IN-1:0] fallSeen,
  output flagStrobe_t [NUM_IN-1:0] strobeVec
);

  logic [NUM_IN-1:0] swSel;
  logic [NUM_IN-1:0] swSet;
  logic [NUM_IN-1:0] swClr;

  assign swSel = swWrMask & {NUM_IN{swWrEn}};
  assign swSet = swSel & swWrVal;
  assign swClr = swSel & ~swWrVal;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_ctl
    logic wantSet;
    logic wantClr;

    // Priority in edge mode: falling edge, then software write, then acknowledge.
    always_comb begin
      wantSet = fallSeen[i] | swSet[i];
      wantClr = swClr[i] | (vecAck[i] & ~swSel[i]);
    end

    always_comb begin
      strobeVec[i].track = ~edgeMode[i];
      strobeVec[i].setF  = edgeMode[i] & wantSet;
      strobeVec[i].clrF  = edgeMode[i] & ~wantSet & wantClr;
    end
  end

endmodule

// File: rtl/ext_int_conditioner.sv
module ext_int_conditioner
  import ext_int_pkg::*;
#(
  parameter int NUM_IN      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] pinN,
  input  logic [NUM_IN-1:0] edgeMode,
  input  logic [NUM_IN-1:0] vecAck,
  input  logic              swWrEn,
  input  logic [NUM_IN-1:0] swWrMask,
  input  logic [NUM_IN-1:0] swWrVal,
  output logic [NUM_IN-1:0] pending
);

  flagStrobe_t [NUM_IN-1:0] strobeVec;
  logic        [NUM_IN-1:0] fallSeen;

  ext_int_control #(
    .NUM_IN (NUM_IN)
  ) ctl_i (
    .edgeMode  (edgeMode),
    .vecAck    (vecAck),
    .swWrEn    (swWrEn),
    .swWrMask  (swWrMask),
    .swWrVal   (swWrVal),
    .fallSeen  (fallSeen),
    .strobeVec (strobeVec)
  );

  ext_int_datapath #(
    .NUM_IN      (NUM_IN),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pinN      (pinN),
    .strobeVec (strobeVec),
    .fallSeen  (fallSeen),
    .flagQ     (pending)
  );

endmodule

// File: rtl/ext_int_conditioner_chk.sv
module ext_int_conditioner_chk #(
  parameter int NUM_IN      = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_IN-1:0] pinN,
  input logic [NUM_IN-1:0] edgeMode,
  input logic [NUM_IN-1:0] vecAck,
  input logic              swWrEn,
  input logic [NUM_IN-1:0] swWrMask,
  input logic [NUM_IN-1:0] swWrVal,
  input logic [NUM_IN-1:0] pending
);

  localparam int LAT   = SYNC_STAGES + 1;
  localparam int READY = LAT + 2;

  logic [3:0] sinceRst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sinceRst <= '0;
    end else if (sinceRst != 4'hF) begin
      sinceRst <= sinceRst + 4'd1;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    // R3: level mode copies the inverted pin after the fixed latency.
    a_r3_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (sinceRst >= READY && !$past(edgeMode[i])) |-> (pending[i] == !$past(pinN[i], LAT)));

    // R6: in edge mode a flag rises only on a falling pin or a software set.
    a_r6_edge_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (sinceRst >= READY && $past(edgeMode[i]) && $rose(pending[i])
       && !$past(swWrEn && swWrMask[i] && swWrVal[i]))
      |-> ($past(pinN[i], LAT + 1) && !$past(pinN[i], LAT)));

    // R9: a detected falling edge always sets the flag, acknowledge or not.
    a_r9_edge_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
      (sinceRst >= READY && $past(edgeMode[i])
       && $past(pinN[i], LAT + 1) && !$past(pinN[i], LAT)) |-> pending[i]);

    // R8: an acknowledge with no coincident edge or write clears the flag.
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sinceRst >= READY && $past(edgeMode[i] && vecAck[i] && !(swWrEn && swWrMask[i]))
       && !($past(pinN[i], LAT + 1) && !$past(pinN[i], LAT))) |-> !pending[i]);

    // R7: a set edge-mode flag holds without acknowledge or software write.
    a_r7_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $past(edgeMode[i] && pending[i] && !vecAck[i] && !(swWrEn && swWrMask[i]))
      |-> pending[i]);
  end

endmodule

bind ext_int_conditioner ext_int_conditioner_chk #(
  .NUM_IN      (NUM_IN),
  .SYNC_STAGES (SYNC_STAGES)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pinN     (pinN),
  .edgeMode (edgeMode),
  .vecAck   (vecAck),
  .swWrEn   (swWrEn),
  .swWrMask (swWrMask),
  .swWrVal  (swWrVal),
  .pending  (pending)
);

// File: tb/ext_int_conditioner_tb_top.sv
`timescale 1ns/1ps
module ext_int_conditioner_tb_top;

  localparam int NUM_IN = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_IN-1:0] pinN = '1;
  logic [NUM_IN-1:0] edgeMode = '0;
  logic [NUM_IN-1:0] vecAck = '0;
  logic              swWrEn = 1'b0;
  logic [NUM_IN-1:0] swWrMask = '0;
  logic [NUM_IN-1:0] swWrVal = '0;
  logic [NUM_IN-1:0] pending;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_int_conditioner #(.NUM_IN(NUM_IN), .SYNC_STAGES(2)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinN     (pinN),
    .edgeMode (edgeMode),
    .vecAck   (vecAck),
    .swWrEn   (swWrEn),
    .swWrMask (swWrMask),
    .swWrVal  (swWrVal),
    .pending  (pending)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [NUM_IN-1:0] mask, input logic [NUM_IN-1:0] val);
    swWrEn = 1'b1; swWrMask = mask; swWrVal = val;
    tick(1);
    swWrEn = 1'b0; swWrMask = '0; swWrVal = '0;
  endtask

  // Return to a quiet state: pins high, given modes, flags cleared.
  task automatic settle(input logic [NUM_IN-1:0] modes);
    pinN = '1; vecAck = '0; edgeMode = modes;
    tick(5);
    sw_write('1, '0);
    tick(1);
  endtask

  task automatic t_reset();
    chk("R1 reset pending0", pending[0], 1'b0);
    chk("R1 reset pending1", pending[1], 1'b0);
  endtask

  task automatic t_level();
    settle(2'b00);
    pinN[0] = 1'b0;
    tick(2);
    chk("R2 not yet visible", pending[0], 1'b0);
    tick(1);
    chk("R2 R3 level low seen", pending[0], 1'b1);
    vecAck[0] = 1'b1; tick(1); vecAck[0] = 1'b0;
    chk("R4 ack ignored in level", pending[0], 1'b1);
    tick(3);
    chk("R4 re-request while low", pending[0], 1'b1);
    sw_write(2'b01, 2'b00);
    chk("R5 sw clear ignored", pending[0], 1'b1);
    pinN[0] = 1'b1;
    tick(3);
    chk("R3 level follows release", pending[0], 1'b0);
    sw_write(2'b01, 2'b01);
    chk("R5 sw set ignored", pending[0], 1'b0);
  endtask

  task automatic t_edge();
    settle(2'b11);
    pinN[0] = 1'b0;
    tick(2);
    chk("R6 edge not yet", pending[0], 1'b0);
    tick(1);
    chk("R6 edge sets", pending[0], 1'b1);
    tick(4);
    chk("R7 holds while low", pending[0], 1'b1);
    pinN[0] = 1'b1;
    tick(5);
    chk("R7 holds after rise", pending[0], 1'b1);
    vecAck[0] = 1'b1; tick(1); vecAck[0] = 1'b0;
    chk("R8 ack clears", pending[0], 1'b0);
    pinN[0] = 1'b0;
    tick(4);
    vecAck[0] = 1'b1; tick(1); vecAck[0] = 1'b0;
    chk("R8 ack clears second", pending[0], 1'b0);
    tick(6);
    chk("R6 no reset while low", pending[0], 1'b0);
    pinN[0] = 1'b1;
    tick(5);
    chk("R6 rise sets nothing", pending[0], 1'b0);
  endtask

  task automatic t_coincide();
    settle(2'b11);
    pinN[0] = 1'b0;
    tick(2);
    vecAck[0] = 1'b1; tick(1); vecAck[0] = 1'b0;
    chk("R9 edge with ack kept", pending[0], 1'b1);
    pinN[0] = 1'b1;
    tick(4);
    pinN[0] = 1'b0;
    tick(2);
    sw_write(2'b01, 2'b00);
    chk("R10 edge beats sw clear", pending[0], 1'b1);
  endtask

  task automatic t_sw();
    settle(2'b11);
    sw_write(2'b01, 2'b01);
    chk("R10 sw set", pending[0], 1'b1);
    chk("R10 mask keeps other", pending[1], 1'b0);
    sw_write(2'b01, 2'b00);
    chk("R10 sw clear", pending[0], 1'b0);
    vecAck[0] = 1'b1;
    sw_write(2'b01, 2'b01);
    vecAck[0] = 1'b0;
    chk("R10 sw set beats ack", pending[0], 1'b1);
    sw_write(2'b10, 2'b00);
    chk("R10 unmasked bit untouched", pending[0], 1'b1);
  endtask

  task automatic t_indep();
    settle(2'b10);
    pinN[1] = 1'b0;
    tick(3);
    chk("R11 edge input sets", pending[1], 1'b1);
    chk("R11 level input idle", pending[0], 1'b0);
    pinN[0] = 1'b0; pinN[1] = 1'b1;
    tick(3);
    chk("R11 level input follows", pending[0], 1'b1);
    chk("R11 edge input holds", pending[1], 1'b1);
    vecAck[1] = 1'b1; tick(1); vecAck[1] = 1'b0;
    chk("R11 ack1 clears own", pending[1], 1'b0);
    chk("R11 ack1 spares other", pending[0], 1'b1);
  endtask

  initial begin
    tick(3);
    chk("R1 during reset", pending[0] | pending[1], 1'b0);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_level();
    t_edge();
    t_coincide();
    t_sw();
    t_indep();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule